// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides which interrupt a 16550-style serial port reports and drives its single interrupt line. Five sources feed it: receiver line errors, received data at or above the FIFO trigger level, a receive character timeout, an empty transmit holding register and modem-status changes. The block holds the pending state of the latched sources and masks every source with the enable bits. It picks the source with the highest priority and presents it as an 8-bit identification value. Each source is cleared by the register access that services it. The receive-timeout counter sits inside the block and counts four character times since the last FIFO access.

The enclosing register file decodes the bus and passes one-cycle strobes for the accesses that matter here. Those strobes are a receive-buffer read, which is also the FIFO pop, a FIFO push, reads of the line-status, modem-status and identification registers, and a write of the transmit holding register. Level inputs carry the receive FIFO count, the trigger-level code, the baud divisor and the total bits per character.

The timeout counter is a three-state machine. In `TO_IDLE` the FIFO is empty. `TO_IDLE` goes to `TO_COUNT` when the count becomes non-zero. In `TO_COUNT` the timer runs, and any FIFO access restarts it. `TO_COUNT` goes to `TO_FIRED` when the timer reaches the limit. `TO_FIRED` goes back to `TO_COUNT` on any FIFO access. Both `TO_COUNT` and `TO_FIRED` go to `TO_IDLE` when the FIFO empties.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, with nothing pending, `iir` reads 8'hC1. Bits 7:4 of `iir` always read 4'b1100. Bit 0 of `iir` is 0 exactly when an enabled source is pending.
- R2: Each enable bit gates its own sources. `ier_bits[0]` gates received data and timeout. `ier_bits[1]` gates holding-register empty. `ier_bits[2]` gates line status. `ier_bits[3]` gates modem status. A disabled source is neither reported nor raises `irq`.
- R3: `iir[3:1]` shows the highest-priority enabled pending source. The order is line status (3'b011), then received data (3'b010), then timeout (3'b110), then holding-register empty (3'b001), then modem status (3'b000).
- R4: The received-data source is active while `rx_level` is at least the trigger level. `trig_code` 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 entries.
- R5: With the FIFO non-empty, the timeout source becomes pending `64*divisor*char_bits` clock edges after the edge that sampled the last FIFO access. That is four character times of 16 ticks per bit.
- R6: A push or a receive-buffer read restarts the timeout count. A receive-buffer read clears a pending timeout. The timeout is never reported while `rx_level` is 0.
- R7: The line-status source is set by a rising edge of `line_err`. It is cleared by `lsr_rd`.
- R8: The modem-status source is set by a rising edge of `modem_delta`. It is cleared by `msr_rd`. A level that stays high does not set it again.
- R9: The holding-register-empty source is set by a rising edge of `thr_empty`. It is cleared by `thr_wr`. It is also cleared by `iir_rd`, but only in a cycle where it is the reported source. An `iir_rd` in any other cycle leaves it pending.
- R10: `irq` is registered. It equals the value of `~iir[0]` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_bits | input | 4 | Interrupt enable bits |
| trig_code | input | 2 | Receive trigger-level select |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | One-cycle strobe: a character was written into the receive FIFO |
| rbr_rd | input | 1 | One-cycle strobe: receive buffer read (FIFO pop) |
| line_err | input | 1 | Receiver line-status error flag |
| lsr_rd | input | 1 | One-cycle strobe: line-status register read |
| modem_delta | input | 1 | Any modem-status change flag |
| msr_rd | input | 1 | One-cycle strobe: modem-status register read |
| thr_empty | input | 1 | Transmit holding register empty flag |
| thr_wr | input | 1 | One-cycle strobe: holding register write |
| iir_rd | input | 1 | One-cycle strobe: identification register read |
| divisor | input | DIV_W | Baud divisor, at least 1 |
| char_bits | input | BITS_W | Bits per character including start, parity and stop |
| irq | output | 1 | Registered interrupt request |
| iir | output | 8 | Interrupt identification value |

## Verification
`iir` is combinational from the inputs and the latched state. A change on `rx_level`, `trig_code` or `ier_bits` therefore shows on `iir` in the same cycle. A latched source, which is set by an edge or cleared by a strobe, shows on `iir` after the next clock edge. `irq` follows one edge after `iir`. The bench drives inputs 1 ns after a rising edge and samples just before the next one. The timeout is checked on both sides of its edge: one cycle before `64*divisor*char_bits` edges it must still be absent, and at that edge it must appear. `irq` must still be low at that edge and high one edge later. The trigger levels and the enable-mask priority are swept exhaustively against values the bench computes itself.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Identification codes; the numeric values are read by software.
    typedef enum logic [2:0] {
        ID_MODEM   = 3'b000,
        ID_THRE    = 3'b001,
        ID_RXDATA  = 3'b010,
        ID_LINE    = 3'b011,
        ID_TIMEOUT = 3'b110
    } irq_id_e;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_COUNT,
        TO_FIRED
    } to_state_e;

    localparam logic [3:0] IIR_UPPER = 4'b1100;

    // Latched edge-set sources, index into the flag vector
    localparam int FL_LINE  = 0;
    localparam int FL_THRE  = 1;
    localparam int FL_MODEM = 2;
    localparam int FL_NUM   = 3;

    function automatic int unsigned trig_level(input logic [1:0] code);
        unique case (code)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    output logic pend
);
    logic src_q;
    logic rise;

    assign rise = src & ~src_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            src_q <= src;
            // a new event in the clearing cycle keeps the source pending
            pend  <= rise | (pend & ~clr);
        end
    end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
    import uart_irq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int DIV_W  = 16,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic              fifo_access,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [BITS_W-1:0] char_bits,
    output logic              fired
);
    localparam int TMR_W = DIV_W + BITS_W + 6;

    to_state_e        state, state_n;
    logic [TMR_W-1:0] tmr, tmr_n;
    logic [TMR_W-1:0] limit;
    logic             nonempty;

    // four characters of sixteen ticks per bit
    assign limit    = (TMR_W'(divisor) * TMR_W'(char_bits)) << 6;
    assign nonempty = (fifo_cnt != '0);

    always_comb begin
        state_n = state;
        tmr_n   = tmr;
        unique case (state)
            TO_IDLE: begin
                if (nonempty) begin
                    state_n = TO_COUNT;
                    tmr_n   = '0;
                end
            end
            TO_COUNT: begin
                if (!nonempty) begin
                    state_n = TO_IDLE;
                end else if (fifo_access) begin
                    tmr_n = '0;
                end else if (tmr >= limit - 1'b1) begin
                    state_n = TO_FIRED;
                end else begin
                    tmr_n = tmr + 1'b1;
                end
            end
            TO_FIRED: begin
                if (!nonempty) begin
                    state_n = TO_IDLE;
                end else if (fifo_access) begin
                    state_n = TO_COUNT;
                    tmr_n   = '0;
                end
            end
            default: state_n = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= tmr_n;
        end
    end

    always_comb begin
        fired = (state == TO_FIRED) && nonempty;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic    line_p,
    input  logic    rxdata_p,
    input  logic    timeout_p,
    input  logic    thre_p,
    input  logic    modem_p,
    output irq_id_e id,
    output logic    any
);
    always_comb begin
        any = line_p | rxdata_p | timeout_p | thre_p | modem_p;
        if (line_p)         id = ID_LINE;
        else if (rxdata_p)  id = ID_RXDATA;
        else if (timeout_p) id = ID_TIMEOUT;
        else if (thre_p)    id = ID_THRE;
        else                id = ID_MODEM;
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16,
    parameter int BITS_W     = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ier_bits,
    input  logic [1:0]        trig_code,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              rx_push,
    input  logic              rbr_rd,
    input  logic              line_err,
    input  logic              lsr_rd,
    input  logic              modem_delta,
    input  logic              msr_rd,
    input  logic              thr_empty,
    input  logic              thr_wr,
    input  logic              iir_rd,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [BITS_W-1:0] char_bits,
    output logic              irq,
    output logic [7:0]        iir
);
    logic [FL_NUM-1:0] fl_src, fl_clr, fl_pend;
    logic              to_fired;
    logic              rxdata;
    irq_id_e           cur_id;
    logic              cur_any;
    logic              thre_shown;

    assign rxdata = int'(rx_level) >= int'(trig_level(trig_code));

    uart_irq_timeout #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W),
        .BITS_W(BITS_W)
    ) u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_cnt   (rx_level),
        .fifo_access(rx_push | rbr_rd),
        .divisor    (divisor),
        .char_bits  (char_bits),
        .fired      (to_fired)
    );

    assign thre_shown = iir_rd && cur_any && (cur_id == ID_THRE);

    assign fl_src[FL_LINE]  = line_err;
    assign fl_clr[FL_LINE]  = lsr_rd;
    assign fl_src[FL_THRE]  = thr_empty;
    assign fl_clr[FL_THRE]  = thr_wr | thre_shown;
    assign fl_src[FL_MODEM] = modem_delta;
    assign fl_clr[FL_MODEM] = msr_rd;

    for (genvar g = 0; g < FL_NUM; g++) begin : g_flag
        uart_irq_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .src  (fl_src[g]),
            .clr  (fl_clr[g]),
            .pend (fl_pend[g])
        );
    end

    uart_irq_prio u_prio (
        .line_p   (fl_pend[FL_LINE]  & ier_bits[2]),
        .rxdata_p (rxdata            & ier_bits[0]),
        .timeout_p(to_fired          & ier_bits[0]),
        .thre_p   (fl_pend[FL_THRE]  & ier_bits[1]),
        .modem_p  (fl_pend[FL_MODEM] & ier_bits[3]),
        .id       (cur_id),
        .any      (cur_any)
    );

    assign iir = {IIR_UPPER, cur_id, ~cur_any};

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cur_any;
    end
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       iir,
    input logic             irq,
    input logic [CNT_W-1:0] rx_level,
    input logic             rbr_rd,
    input logic             lsr_rd,
    input logic             line_err,
    input logic             msr_rd,
    input logic             modem_delta,
    input logic             thr_wr,
    input logic             thr_empty
);
    // R1
    upper_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:4] == 4'b1100);

    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == !$past(iir[0]));

    // R6
    to_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iir[0] && iir[3:1] == 3'b110) |-> rx_level != '0);

    // R6
    rbr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd |=> !(!iir[0] && iir[3:1] == 3'b110));

    // R7
    lsr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !line_err) |=> !(!iir[0] && iir[3:1] == 3'b011));

    // R8
    msr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !modem_delta) |=> !(!iir[0] && iir[3:1] == 3'b000));

    // R9
    thr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty) |=> !(!iir[0] && iir[3:1] == 3'b001));
endmodule

bind uart_irq_id uart_irq_id_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iir        (iir),
    .irq        (irq),
    .rx_level   (rx_level),
    .rbr_rd     (rbr_rd),
    .lsr_rd     (lsr_rd),
    .line_err   (line_err),
    .msr_rd     (msr_rd),
    .modem_delta(modem_delta),
    .thr_wr     (thr_wr),
    .thr_empty  (thr_empty)
);

// File: tb/test_uart_irq_id.sv
module test_uart_irq_id;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0]       ier_bits;
    logic [1:0]       trig_code;
    logic [CNT_W-1:0] rx_level;
    logic             rx_push, rbr_rd, line_err, lsr_rd, modem_delta, msr_rd;
    logic             thr_empty, thr_wr, iir_rd;
    logic [15:0]      divisor;
    logic [3:0]       char_bits;
    logic             irq;
    logic [7:0]       iir;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uart_irq_id i_uart_irq_id (
        .clk(clk), .rst_n(rst_n), .ier_bits(ier_bits), .trig_code(trig_code),
        .rx_level(rx_level), .rx_push(rx_push), .rbr_rd(rbr_rd),
        .line_err(line_err), .lsr_rd(lsr_rd), .modem_delta(modem_delta),
        .msr_rd(msr_rd), .thr_empty(thr_empty), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .divisor(divisor), .char_bits(char_bits),
        .irq(irq), .iir(iir)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] prio_exp(input logic [3:0] e);
        if (e[2])      return 8'hC6;
        else if (e[0]) return 8'hC4;
        else if (e[1]) return 8'hC2;
        else if (e[3]) return 8'hC0;
        else           return 8'hC1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lim;
        rst_n = 0; ier_bits = 0; trig_code = 0; rx_level = 0; rx_push = 0;
        rbr_rd = 0; line_err = 0; lsr_rd = 0; modem_delta = 0; msr_rd = 0;
        thr_empty = 0; thr_wr = 0; iir_rd = 0; divisor = 16'd1; char_bits = 4'd10;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 reset iir", iir, 8'hC1);
        chk("R10 reset irq", {7'd0, irq}, 8'h00);

        // R4 trigger sweep, R10 registered irq
        ier_bits = 4'b0001;
        for (int tc = 0; tc < 4; tc++) begin
            int lvl;
            trig_code = 2'(tc);
            lvl = (tc == 0) ? 1 : (tc == 1) ? 4 : (tc == 2) ? 8 : 14;
            for (int n = 0; n <= 16; n++) begin
                rx_level = CNT_W'(n);
                tick();
                chk("R4 trigger", iir, (n >= lvl) ? 8'hC4 : 8'hC1);
                chk("R10 irq", {7'd0, irq}, (n >= lvl) ? 8'h01 : 8'h00);
            end
            rx_level = 0;
            tick();
        end

        // R5 timeout edge
        divisor = 16'd2; char_bits = 4'd7; lim = 64 * 2 * 7;
        trig_code = 2'd1;
        rx_level = 2; rx_push = 1;
        tick();
        rx_push = 0;
        repeat (lim - 1) tick();
        chk("R5 before timeout", iir, 8'hC1);
        tick();
        chk("R5 timeout", iir, 8'hCC);
        chk("R10 irq lag", {7'd0, irq}, 8'h00);
        tick();
        chk("R10 irq follows", {7'd0, irq}, 8'h01);

        // R6 read clears, push restarts
        rbr_rd = 1;
        tick();
        rbr_rd = 0;
        chk("R6 rbr clears timeout", iir, 8'hC1);
        repeat (lim / 2) tick();
        rx_push = 1;
        tick();
        rx_push = 0;
        repeat (lim - 1) tick();
        chk("R6 restart", iir, 8'hC1);
        tick();
        chk("R6 restarted timeout", iir, 8'hCC);
        rx_level = 0;
        #1;
        chk("R6 empty hides", iir, 8'hC1);
        repeat (lim + 5) tick();
        chk("R6 empty never fires", iir, 8'hC1);

        // R2/R3 priority with every source pending
        divisor = 16'd1; char_bits = 4'd10; lim = 640;
        ier_bits = 0; trig_code = 0;
        rx_level = 14; rx_push = 1;
        tick();
        rx_push = 0;
        repeat (lim + 2) tick();
        line_err = 1; thr_empty = 1; modem_delta = 1;
        tick();
        line_err = 0;
        tick();
        for (int e = 0; e < 16; e++) begin
            ier_bits = 4'(e);
            tick();
            chk("R2 R3 mask/priority", iir, prio_exp(4'(e)));
            chk("R2 irq mask", {7'd0, irq}, (e != 0) ? 8'h01 : 8'h00);
        end

        // R9 identification read while another source shown is ignored
        ier_bits = 4'hF;
        iir_rd = 1;
        tick();
        iir_rd = 0;
        chk("R3 line first", iir, 8'hC6);
        lsr_rd = 1;
        tick();
        lsr_rd = 0;
        chk("R7 lsr read clears", iir, 8'hC4);
        trig_code = 2'd1; rx_level = 3;
        #1;
        chk("R3 timeout over thre", iir, 8'hCC);
        rbr_rd = 1;
        tick();
        rbr_rd = 0;
        chk("R9 thre kept after unrelated iir read", iir, 8'hC2);
        iir_rd = 1;
        tick();
        iir_rd = 0;
        chk("R9 iir read clears thre", iir, 8'hC0);
        msr_rd = 1;
        tick();
        msr_rd = 0;
        tick();
        chk("R8 msr read clears, held level no reset", iir, 8'hC1);
        modem_delta = 0;
        rx_level = 0;

        // R9 write clears
        thr_empty = 0;
        tick();
        thr_empty = 1;
        tick();
        chk("R9 thre set on edge", iir, 8'hC2);
        thr_wr = 1;
        tick();
        thr_wr = 0;
        chk("R9 write clears", iir, 8'hC1);

        // R7 rising edge sets again
        line_err = 1;
        tick();
        line_err = 0;
        chk("R7 line set", iir, 8'hC6);
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule